// File: doc/BRIEF.md
# Ring-Ordered Register Forwarding Network

This block holds a circular window of instruction stations and, for every station, gives the complete set of logical register values that the station would read, with one ready bit per register. Entries go in at the tail and leave from the head, both in program order. When the head entry has finished and retires, its result is written into the committed register file. No rename table, associative wakeup or bypass comparator is needed. Each station passes each register through unchanged unless it writes that register itself. A parallel-prefix tree combines these pass-or-produce decisions across the ring in a number of levels that grows with the logarithm of the window size.

Each station keeps a valid bit, a write-enable, a destination register index, a result word and a done flag. The ring is cut just before the head station. The committed register file enters the ring at that point as a producer of every register, and it is always ready. A station therefore sees the result of the nearest older in-window writer of each register, or the committed value when no such writer exists. The window size must be a power of two.

Top module: `ring_fwd_net`

## Requirements
- R1: After reset the window is empty, head and tail are 0, `full_o` is 0, and every station sees every register as value 0 with its ready bit at 1.
- R2: For each station and register, `view_data_o` equals the result of the nearest older valid writer of that register. The search runs backward from the station toward the head. If no such writer exists, the output is the committed value.
- R3: `view_rdy_o` equals the done flag of the producer chosen under R2, or 1 when the committed value is chosen.
- R4: The search in R2 wraps around the ring. A station at a lower index than the head sees producers at higher indices, back to the head.
- R5: An insert is accepted only while the window is not full. It fills the tail station and advances the tail by one. An insert while `full_o` is 1 leaves the tail and all views unchanged.
- R6: A completion to a valid station that is not yet done stores the result and sets done. A completion to an invalid or already-done station has no effect.
- R7: A retire request takes effect only when the head station is valid and done. The committed register file takes the head's result if its write-enable is set, and the head advances by one. Otherwise nothing changes.
- R8: An entry with write-enable 0, and an invalid station, pass every register through unchanged.
- R9: The head station always sees exactly the committed register file, with all ready bits at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ins_valid_i | input | 1 | Insert request at the tail |
| ins_dst_i | input | log2(N_REG) | Destination register of the inserted entry |
| ins_wen_i | input | 1 | Inserted entry writes a register |
| cmp_valid_i | input | 1 | Completion strobe |
| cmp_idx_i | input | log2(N_STN) | Station that completes |
| cmp_data_i | input | DATA_W | Result word of the completing station |
| ret_i | input | 1 | Retire request for the head station |
| head_o | output | log2(N_STN) | Oldest station index |
| tail_o | output | log2(N_STN) | Next free station index |
| full_o | output | 1 | All stations occupied |
| view_data_o | output | N_STN*N_REG*DATA_W | Per-station register view; station i, register r at bits ((i*N_REG+r)*DATA_W) upward |
| view_rdy_o | output | N_STN*N_REG | Per-station ready bits; station i, register r at bit i*N_REG+r |

## Verification
The bench goes after wrap-around. There, the head sits above stations that hold younger entries. A design that cut the prefix at index 0 instead of at the head would hand those stations stale committed values. It targets several writers of one register in flight at once; taking the oldest rather than the nearest producer shows up as a wrong value or ready bit. It also tests inserts into a full window, repeated completions and retires of an unfinished head. A design that ignored the guards would overwrite live entries, or commit garbage and advance the head early. Every cycle, all station views are compared against a backward-scan model.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int DEF_N_STN  = 8;
  localparam int DEF_N_REG  = 8;
  localparam int DEF_DATA_W = 16;
endpackage

// File: rtl/fwd_prefix.sv
// Inclusive Kogge-Stone prefix; element = {gen, rdy, data}, later generator wins.
module fwd_prefix #(
  parameter int N_EL = 16,
  parameter int W    = 18
) (
  input  logic [N_EL-1:0][W-1:0] elem_i,
  output logic [N_EL-1:0][W-1:0] pre_o
);
  localparam int LV = $clog2(N_EL);

  logic [LV:0][N_EL-1:0][W-1:0] lvl;

  function automatic logic [W-1:0] comb(input logic [W-1:0] early, input logic [W-1:0] late);
    return late[W-1] ? late : early;
  endfunction

  assign lvl[0] = elem_i;

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    for (genvar k = 0; k < N_EL; k++) begin : g_el
      if (k >= (1 << l)) begin : g_cmb
        assign lvl[l+1][k] = comb(lvl[l][k-(1<<l)], lvl[l][k]);
      end else begin : g_pass
        assign lvl[l+1][k] = lvl[l][k];
      end
    end
  end

  assign pre_o = lvl[LV];
endmodule

// File: rtl/fwd_window_ctl.sv
module fwd_window_ctl #(
  parameter int N_STN  = fwd_pkg::DEF_N_STN,
  parameter int N_REG  = fwd_pkg::DEF_N_REG,
  parameter int DATA_W = fwd_pkg::DEF_DATA_W,
  localparam int STN_W = $clog2(N_STN),
  localparam int REG_W = $clog2(N_REG)
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               ins_valid_i,
  input  logic [REG_W-1:0]                   ins_dst_i,
  input  logic                               ins_wen_i,
  input  logic                               cmp_valid_i,
  input  logic [STN_W-1:0]                   cmp_idx_i,
  input  logic [DATA_W-1:0]                  cmp_data_i,
  input  logic                               ret_i,
  output logic [N_STN-1:0]                   vld_o,
  output logic [N_STN-1:0]                   wen_o,
  output logic [N_STN-1:0]                   done_o,
  output logic [N_STN-1:0][REG_W-1:0]        dst_o,
  output logic [N_STN-1:0][DATA_W-1:0]       dat_o,
  output logic [N_REG-1:0][DATA_W-1:0]       arch_o,
  output logic [STN_W-1:0]                   head_o,
  output logic [STN_W-1:0]                   tail_o,
  output logic [STN_W:0]                     count_o,
  output logic                               ret_fire_o
);
  logic full, ins_fire, cmp_fire;

  assign full       = (count_o == (STN_W+1)'(N_STN));
  assign ins_fire   = ins_valid_i & ~full;
  assign cmp_fire   = cmp_valid_i & vld_o[cmp_idx_i] & ~done_o[cmp_idx_i];
  assign ret_fire_o = ret_i & vld_o[head_o] & done_o[head_o];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= '0;
      wen_o   <= '0;
      done_o  <= '0;
      dst_o   <= '0;
      dat_o   <= '0;
      arch_o  <= '0;
      head_o  <= '0;
      tail_o  <= '0;
      count_o <= '0;
    end else begin
      if (cmp_fire) begin
        dat_o[cmp_idx_i]  <= cmp_data_i;
        done_o[cmp_idx_i] <= 1'b1;
      end
      if (ret_fire_o) begin
        vld_o[head_o] <= 1'b0;
        if (wen_o[head_o]) arch_o[dst_o[head_o]] <= dat_o[head_o];
        head_o <= head_o + 1'b1;
      end
      if (ins_fire) begin
        vld_o[tail_o]  <= 1'b1;
        wen_o[tail_o]  <= ins_wen_i;
        dst_o[tail_o]  <= ins_dst_i;
        done_o[tail_o] <= 1'b0;
        tail_o <= tail_o + 1'b1;
      end
      count_o <= count_o + (STN_W+1)'(ins_fire) - (STN_W+1)'(ret_fire_o);
    end
  end
endmodule

// File: rtl/ring_fwd_net.sv
module ring_fwd_net #(
  parameter int N_STN  = fwd_pkg::DEF_N_STN,
  parameter int N_REG  = fwd_pkg::DEF_N_REG,
  parameter int DATA_W = fwd_pkg::DEF_DATA_W,
  localparam int STN_W = $clog2(N_STN),
  localparam int REG_W = $clog2(N_REG)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            ins_valid_i,
  input  logic [REG_W-1:0]                ins_dst_i,
  input  logic                            ins_wen_i,
  input  logic                            cmp_valid_i,
  input  logic [STN_W-1:0]                cmp_idx_i,
  input  logic [DATA_W-1:0]               cmp_data_i,
  input  logic                            ret_i,
  output logic [STN_W-1:0]                head_o,
  output logic [STN_W-1:0]                tail_o,
  output logic                            full_o,
  output logic [N_STN*N_REG*DATA_W-1:0]   view_data_o,
  output logic [N_STN*N_REG-1:0]          view_rdy_o
);
  localparam int N_EL = 2 * N_STN;
  localparam int EL_W = DATA_W + 2;

  logic [N_STN-1:0]             vld, wen, done;
  logic [N_STN-1:0][REG_W-1:0]  dst;
  logic [N_STN-1:0][DATA_W-1:0] dat;
  logic [N_REG-1:0][DATA_W-1:0] arch;
  logic [STN_W:0]               count;
  logic                         ret_fire;
  logic [STN_W-1:0]             cut;

  fwd_window_ctl #(.N_STN(N_STN), .N_REG(N_REG), .DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .ins_valid_i, .ins_dst_i, .ins_wen_i,
    .cmp_valid_i, .cmp_idx_i, .cmp_data_i, .ret_i,
    .vld_o(vld), .wen_o(wen), .done_o(done), .dst_o(dst), .dat_o(dat),
    .arch_o(arch), .head_o(head_o), .tail_o(tail_o), .count_o(count),
    .ret_fire_o(ret_fire)
  );

  assign full_o = (count == (STN_W+1)'(N_STN));
  // committed file enters the ring as a producer at the slot just before head
  assign cut = head_o - 1'b1;

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    logic [N_EL-1:0][EL_W-1:0] elem, pre;

    // ring unrolled twice so every station has a full window of older slots
    for (genvar j = 0; j < N_EL; j++) begin : g_el
      localparam int S = j % N_STN;
      always_comb begin
        if (STN_W'(S) == cut) elem[j] = {1'b1, 1'b1, arch[r]};
        else elem[j] = {vld[S] & wen[S] & (dst[S] == REG_W'(r)), done[S], dat[S]};
      end
    end

    fwd_prefix #(.N_EL(N_EL), .W(EL_W)) u_pfx (.elem_i(elem), .pre_o(pre));

    for (genvar i = 0; i < N_STN; i++) begin : g_out
      assign view_data_o[(i*N_REG+r)*DATA_W +: DATA_W] = pre[N_STN+i-1][DATA_W-1:0];
      assign view_rdy_o[i*N_REG+r]                     = pre[N_STN+i-1][DATA_W];
    end
  end
endmodule

// File: rtl/ring_fwd_net_chk.sv
module ring_fwd_net_chk #(
  parameter int N_STN = 8,
  parameter int N_REG = 8,
  localparam int STN_W = $clog2(N_STN)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   ins_valid_i,
  input logic                   full_o,
  input logic                   ret_fire,
  input logic [STN_W:0]         count,
  input logic [STN_W-1:0]       head_o,
  input logic [STN_W-1:0]       tail_o,
  input logic [N_STN*N_REG-1:0] view_rdy_o
);
  p_ins_blocked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && ins_valid_i) |=> (tail_o == $past(tail_o)));

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= (STN_W+1)'(N_STN));

  p_head_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_fire |=> (head_o == STN_W'($past(head_o) + 1'b1)));

  p_empty_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0) |-> (&view_rdy_o));

  p_head_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    &view_rdy_o[head_o*N_REG +: N_REG]);
endmodule

bind ring_fwd_net ring_fwd_net_chk #(.N_STN(N_STN), .N_REG(N_REG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ins_valid_i(ins_valid_i), .full_o(full_o),
  .ret_fire(ret_fire), .count(count), .head_o(head_o), .tail_o(tail_o),
  .view_rdy_o(view_rdy_o)
);

// File: tb/ring_fwd_net_test.sv
module ring_fwd_net_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int NR = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ins_valid = 1'b0, ins_wen = 1'b0, cmp_valid = 1'b0, ret = 1'b0;
  logic [2:0] ins_dst = '0, cmp_idx = '0;
  logic [DW-1:0] cmp_data = '0;
  logic [2:0] head, tail;
  logic full;
  logic [N*NR*DW-1:0] vdata;
  logic [N*NR-1:0] vrdy;

  int checks = 0, errors = 0;
  bit done_flag = 0;

  int mvld[N], mwen[N], mdst[N], mdat[N], mdone[N], march[NR];
  int mhead = 0, mtail = 0, mcount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_fwd_net #(.N_STN(N), .N_REG(NR), .DATA_W(DW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ins_valid_i(ins_valid), .ins_dst_i(ins_dst),
    .ins_wen_i(ins_wen), .cmp_valid_i(cmp_valid), .cmp_idx_i(cmp_idx),
    .cmp_data_i(cmp_data), .ret_i(ret), .head_o(head), .tail_o(tail),
    .full_o(full), .view_data_o(vdata), .view_rdy_o(vrdy)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // backward scan from the station toward the head (R2, R3, R4, R8)
  task automatic expect_view(int i, int r, output int ev, output int er);
    int s = i;
    ev = march[r]; er = 1;
    for (int k = 0; k < N; k++) begin
      if (s == mhead) break;
      s = (s + N - 1) % N;
      if (mvld[s] != 0 && mwen[s] != 0 && mdst[s] == r) begin
        ev = mdat[s]; er = mdone[s];
        break;
      end
    end
  endtask

  task automatic check_all();
    chk("R7 head", int'(head), mhead);
    chk("R5 tail", int'(tail), mtail);
    chk("R5 full", int'(full), int'(mcount == N));
    for (int i = 0; i < N; i++) begin
      for (int r = 0; r < NR; r++) begin
        int ev, er;
        expect_view(i, r, ev, er);
        if (i == mhead) begin
          chk("R9 data", int'(vdata[(i*NR+r)*DW +: DW]), ev);
          chk("R9 rdy", int'(vrdy[i*NR+r]), er);
        end else if (i < mhead) begin
          chk("R4 data", int'(vdata[(i*NR+r)*DW +: DW]), ev);
          chk("R4 rdy", int'(vrdy[i*NR+r]), er);
        end else begin
          chk("R2 data", int'(vdata[(i*NR+r)*DW +: DW]), ev);
          chk("R3 rdy", int'(vrdy[i*NR+r]), er);
        end
      end
    end
  endtask

  task automatic cyc(bit iv, int idst, bit iw, bit cv, int cidx, int cdat, bit rv);
    bit ins_ok, cmp_ok, ret_ok;
    ins_valid = iv; ins_dst = 3'(idst); ins_wen = iw;
    cmp_valid = cv; cmp_idx = 3'(cidx); cmp_data = DW'(cdat);
    ret = rv;
    ins_ok = iv && mcount < N;
    cmp_ok = cv && mvld[cidx] != 0 && mdone[cidx] == 0;
    ret_ok = rv && mvld[mhead] != 0 && mdone[mhead] != 0;
    @(posedge clk);
    if (cmp_ok) begin mdat[cidx] = cdat & 16'hffff; mdone[cidx] = 1; end
    if (ret_ok) begin
      mvld[mhead] = 0;
      if (mwen[mhead] != 0) march[mdst[mhead]] = mdat[mhead];
      mhead = (mhead + 1) % N;
    end
    if (ins_ok) begin
      mvld[mtail] = 1; mwen[mtail] = iw; mdst[mtail] = idst; mdone[mtail] = 0;
      mtail = (mtail + 1) % N;
    end
    mcount = mcount + int'(ins_ok) - int'(ret_ok);
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mvld[i]=0; mwen[i]=0; mdst[i]=0; mdat[i]=0; mdone[i]=0; end
    for (int r = 0; r < NR; r++) march[r] = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: empty, zero pointers, all registers zero and ready
    chk("R1 head", int'(head), 0);
    chk("R1 full", int'(full), 0);
    chk("R1 rdy", int'(&vrdy), 1);
    chk("R1 data", int'(|vdata), 0);
    check_all();

    // fill window with writers of r1 and r2; entry 2 is a non-writer of r1 (R8)
    cyc(1, 1, 1, 0, 0, 0, 0);
    cyc(1, 2, 1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 0);
    chk("R8 pass", int'(vrdy[3*NR+1]), 0);
    for (int k = 0; k < 5; k++) cyc(1, k, 1, 0, 0, 0, 0);
    // R5: insert into full window ignored
    cyc(1, 7, 1, 0, 0, 0, 0);
    chk("R5 blocked", int'(tail), 0);
    // R7: retire of unfinished head ignored
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R7 not done", int'(head), 0);
    // R6: first completion lands, second ignored
    cyc(0, 0, 0, 1, 0, 16'h1234, 0);
    cyc(0, 0, 0, 1, 0, 16'h5555, 0);
    chk("R6 repeat", int'(vdata[(1*NR+1)*DW +: DW]), 16'h1234);
    cyc(0, 0, 0, 1, 1, 16'h00aa, 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R7 commit", int'(vdata[(2*NR+1)*DW +: DW]), 16'h1234);

    // random traffic with wrap-around
    for (int t = 0; t < 6000; t++) begin
      cyc($urandom_range(0, 9) < 6, $urandom_range(0, NR-1), $urandom_range(0, 3) != 0,
          $urandom_range(0, 9) < 7, $urandom_range(0, N-1), $urandom_range(0, 65535),
          $urandom_range(0, 1) == 1);
    end

    done_flag = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule